// File: doc/BRIEF.md
# Statechart Transition Priority Selector

This block decides which statechart transitions fire in a single microstep. It is purely combinational. Each cycle it receives the active-state vector, indexed by document order. It also receives a one-hot vector naming the event being processed, a strobe that permits eventless (spontaneous) transitions, and one condition-satisfied bit per transition. It returns one fire bit per transition, together with three summary flags.

The chart's topology is fixed when the block is built. Parameters give, for each transition:

- its source state;
- its conflict row, naming the lower-ranked transitions it is exclusive with;
- its event-match mask over event indices, with prefix matching of descriptors already folded in;
- whether it carries an event;
- whether it carries a guard.

Transitions are ranked by post-order index. A lower index wins against any higher-indexed transition that lists it as a conflict. Eventless transitions are resolved first. If any of them fires, every event-triggered transition is held off for that step.

Top module: `stc_fire_select`

## Requirements
- R1: A transition fires only while the active bit of its source state is 1.
- R2: An eventless transition can fire only while `spont_en` is 1.
- R3: A guarded transition needs its `cond_ok` bit at 1. For an unguarded transition the `cond_ok` bit has no effect.
- R4: An event-triggered transition is a candidate only when its match mask has a 1 at the bit set in `event_onehot`. Bit k of the mask stands for event index k.
- R5: Transition i is suppressed whenever a transition j < i that has bit j set in row i of the conflict matrix fires. Bit `i*NUM_TRANS+j` of `CONFLICTS` is that flag.
- R6: If any eventless transition fires, no event-triggered transition fires in the same step.
- R7: `eventless_fired` is 1 exactly when some eventless transition fires.
- R8: `event_consumed` is 1 exactly when some event-triggered transition fires.
- R9: `any_fired` is 1 exactly when some bit of `fire_sel` is 1.
- R10: With `event_onehot` all zero, no event-triggered transition fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| active_states | input | NUM_STATES | Current configuration; bit n set means state n is active |
| event_onehot | input | NUM_EVENTS | One-hot current event, or all zero when no event is present |
| spont_en | input | 1 | Permits eventless transitions this step |
| cond_ok | input | NUM_TRANS | Per-transition condition result |
| fire_sel | output | NUM_TRANS | Selected transitions, indexed by post-order |
| eventless_fired | output | 1 | Some eventless transition fired |
| event_consumed | output | 1 | Some event-triggered transition fired |
| any_fired | output | 1 | Some transition fired |

## Verification
Hand-built patterns are applied first, and each one isolates one rule:

- a lone active source with no event, which separates the spontaneous path from the triggered path;
- events that hit one mask and miss another, or that hit two transitions sharing a conflict, which shows whether lower-index precedence holds;
- a guard toggled under an otherwise fixed pattern;
- a spontaneous strobe raised beside a matching event, which shows whether the eventless lockout applies.

A seeded sweep over random configurations, events, strobes and condition bits then compares every output against an independent model of the rules.

// File: rtl/stc_sel_pkg.sv
package stc_sel_pkg;

    typedef enum logic {
        TK_EVENTLESS = 1'b0,
        TK_TRIGGERED = 1'b1
    } trans_kind_e;

endpackage

// File: rtl/stc_trans_qualify.sv
module stc_trans_qualify #(
    parameter int NUM_STATES = 8,
    parameter int NUM_EVENTS = 4,
    parameter int NUM_TRANS  = 6,
    parameter int SRC_W      = $clog2(NUM_STATES),
    parameter logic [NUM_TRANS*SRC_W-1:0]      SRC_STATE = '0,
    parameter logic [NUM_TRANS*NUM_EVENTS-1:0] EVT_MASK  = '0,
    parameter logic [NUM_TRANS-1:0]            HAS_EVENT = '0,
    parameter logic [NUM_TRANS-1:0]            HAS_COND  = '0
) (
    input  logic [NUM_STATES-1:0] active_states,
    input  logic [NUM_EVENTS-1:0] event_onehot,
    input  logic                  spont_en,
    input  logic [NUM_TRANS-1:0]  cond_ok,
    output logic [NUM_TRANS-1:0]  cand_free,
    output logic [NUM_TRANS-1:0]  cand_trig
);
    import stc_sel_pkg::*;

    for (genvar i = 0; i < NUM_TRANS; i++) begin : g_tr
        localparam logic [SRC_W-1:0]      SRC  = SRC_STATE[i*SRC_W +: SRC_W];
        localparam logic [NUM_EVENTS-1:0] MASK = EVT_MASK[i*NUM_EVENTS +: NUM_EVENTS];
        localparam trans_kind_e KIND = HAS_EVENT[i] ? TK_TRIGGERED : TK_EVENTLESS;

        logic src_on;
        logic guard_ok;
        assign src_on   = active_states[SRC];
        assign guard_ok = HAS_COND[i] ? cond_ok[i] : 1'b1;

        always_comb begin
            cand_free[i] = 1'b0;
            cand_trig[i] = 1'b0;
            unique case (KIND)
                TK_EVENTLESS: cand_free[i] = src_on & guard_ok & spont_en;
                TK_TRIGGERED: cand_trig[i] = src_on & guard_ok & (|(MASK & event_onehot));
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/stc_prio_chain.sv
module stc_prio_chain #(
    parameter int NUM_TRANS = 6,
    parameter logic [NUM_TRANS*NUM_TRANS-1:0] CONFLICTS = '0
) (
    input  logic [NUM_TRANS-1:0] cand,
    output logic [NUM_TRANS-1:0] sel
);
    logic [NUM_TRANS-1:0] conf_row [NUM_TRANS];

    for (genvar i = 0; i < NUM_TRANS; i++) begin : g_row
        for (genvar j = 0; j < NUM_TRANS; j++) begin : g_col
            if (j < i) begin : g_lower
                assign conf_row[i][j] = CONFLICTS[i*NUM_TRANS + j];
            end else begin : g_upper
                assign conf_row[i][j] = 1'b0;
            end
        end
    end

    always_comb begin
        logic [NUM_TRANS-1:0] acc;
        acc = '0;
        for (int i = 0; i < NUM_TRANS; i++) begin
            if (cand[i] && !(|(conf_row[i] & acc))) acc[i] = 1'b1;
        end
        sel = acc;
    end
endmodule

// File: rtl/stc_fire_select.sv
module stc_fire_select #(
    parameter int NUM_STATES = 8,
    parameter int NUM_EVENTS = 4,
    parameter int NUM_TRANS  = 6,
    parameter int SRC_W      = $clog2(NUM_STATES),
    parameter logic [NUM_TRANS*SRC_W-1:0]        SRC_STATE = 18'b100_001_011_001_010_001,
    parameter logic [NUM_TRANS*NUM_TRANS-1:0]    CONFLICTS = 36'h6_0408_1040,
    parameter logic [NUM_TRANS*NUM_EVENTS-1:0]   EVT_MASK  = 24'hF9_4300,
    parameter logic [NUM_TRANS-1:0]              HAS_EVENT = 6'b111100,
    parameter logic [NUM_TRANS-1:0]              HAS_COND  = 6'b001010
) (
    input  logic [NUM_STATES-1:0] active_states,
    input  logic [NUM_EVENTS-1:0] event_onehot,
    input  logic                  spont_en,
    input  logic [NUM_TRANS-1:0]  cond_ok,
    output logic [NUM_TRANS-1:0]  fire_sel,
    output logic                  eventless_fired,
    output logic                  event_consumed,
    output logic                  any_fired
);
    logic [NUM_TRANS-1:0] cand_free, cand_trig;
    logic [NUM_TRANS-1:0] sel_free, sel_trig;

    stc_trans_qualify #(
        .NUM_STATES(NUM_STATES), .NUM_EVENTS(NUM_EVENTS), .NUM_TRANS(NUM_TRANS),
        .SRC_W(SRC_W), .SRC_STATE(SRC_STATE), .EVT_MASK(EVT_MASK),
        .HAS_EVENT(HAS_EVENT), .HAS_COND(HAS_COND)
    ) qual_i (
        .active_states(active_states), .event_onehot(event_onehot),
        .spont_en(spont_en), .cond_ok(cond_ok),
        .cand_free(cand_free), .cand_trig(cand_trig)
    );

    stc_prio_chain #(.NUM_TRANS(NUM_TRANS), .CONFLICTS(CONFLICTS)) chain_free_i (
        .cand(cand_free), .sel(sel_free)
    );

    stc_prio_chain #(.NUM_TRANS(NUM_TRANS), .CONFLICTS(CONFLICTS)) chain_trig_i (
        .cand(cand_trig), .sel(sel_trig)
    );

    always_comb begin
        eventless_fired = |sel_free;
        fire_sel        = eventless_fired ? sel_free : sel_trig;
        event_consumed  = |(fire_sel & HAS_EVENT);
        any_fired       = |fire_sel;
    end
endmodule

// File: rtl/stc_fire_select_chk.sv
module stc_fire_select_chk #(
    parameter int NUM_STATES = 8,
    parameter int NUM_EVENTS = 4,
    parameter int NUM_TRANS  = 6,
    parameter int SRC_W      = $clog2(NUM_STATES),
    parameter logic [NUM_TRANS*SRC_W-1:0]      SRC_STATE = '0,
    parameter logic [NUM_TRANS*NUM_TRANS-1:0]  CONFLICTS = '0,
    parameter logic [NUM_TRANS-1:0]            HAS_EVENT = '0
) (
    input logic [NUM_STATES-1:0] active_states,
    input logic [NUM_EVENTS-1:0] event_onehot,
    input logic                  spont_en,
    input logic [NUM_TRANS-1:0]  fire_sel,
    input logic                  eventless_fired,
    input logic                  event_consumed
);
    always_comb begin
        if (!$isunknown({active_states, event_onehot, spont_en, fire_sel,
                         eventless_fired, event_consumed})) begin
            for (int i = 0; i < NUM_TRANS; i++) begin
                AST_SRC_ACTIVE: assert (!fire_sel[i] || active_states[SRC_STATE[i*SRC_W +: SRC_W]]); // R1
                for (int j = 0; j < i; j++) begin
                    AST_NO_CONFLICT_PAIR: assert (!(CONFLICTS[i*NUM_TRANS + j] && fire_sel[i] && fire_sel[j])); // R5
                end
            end
            AST_EVENTLESS_LOCKOUT: assert (!eventless_fired || !(|(fire_sel & HAS_EVENT))); // R6
            AST_FLAGS_EXCLUSIVE: assert (!(eventless_fired && event_consumed)); // R6
            AST_SPONT_GATE: assert (spont_en || !eventless_fired); // R2
            AST_NO_EVENT_NO_TRIG: assert ((|event_onehot) || !event_consumed); // R10
        end
    end
endmodule

bind stc_fire_select stc_fire_select_chk #(
    .NUM_STATES(NUM_STATES), .NUM_EVENTS(NUM_EVENTS), .NUM_TRANS(NUM_TRANS),
    .SRC_W(SRC_W), .SRC_STATE(SRC_STATE), .CONFLICTS(CONFLICTS), .HAS_EVENT(HAS_EVENT)
) chk_i (
    .active_states(active_states), .event_onehot(event_onehot), .spont_en(spont_en),
    .fire_sel(fire_sel), .eventless_fired(eventless_fired), .event_consumed(event_consumed)
);

// File: tb/stc_fire_select_tb.sv
module stc_fire_select_tb_top;
    localparam int NS = 8;
    localparam int NE = 4;
    localparam int NT = 6;

    typedef struct packed {
        logic [NT-1:0] sel;
        logic          efree;
        logic          econs;
        logic          anyf;
        logic [7:0]    tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [NS-1:0] active_states = '0;
    logic [NE-1:0] event_onehot  = '0;
    logic          spont_en      = 1'b0;
    logic [NT-1:0] cond_ok       = '0;
    logic [NT-1:0] fire_sel;
    logic          eventless_fired, event_consumed, any_fired;

    stc_fire_select dut_i (
        .active_states(active_states), .event_onehot(event_onehot), .spont_en(spont_en),
        .cond_ok(cond_ok), .fire_sel(fire_sel), .eventless_fired(eventless_fired),
        .event_consumed(event_consumed), .any_fired(any_fired)
    );

    // Topology of the default chart, restated from the requirements' point of view
    int           m_src  [NT] = '{1, 2, 1, 3, 1, 4};
    logic [NE-1:0] m_mask [NT] = '{4'b0000, 4'b0000, 4'b0011, 4'b0100, 4'b1001, 4'b1111};
    bit           m_evt  [NT] = '{0, 0, 1, 1, 1, 1};
    bit           m_grd  [NT] = '{0, 1, 0, 1, 0, 1'b0};
    // loser -> list of winners it yields to
    bit           m_yield [NT][NT];

    exp_t sb_q[$];
    int n_chk = 0;
    int n_bad = 0;

    function automatic exp_t model(logic [NS-1:0] a, logic [NE-1:0] e, logic s,
                                   logic [NT-1:0] c, logic [7:0] tag);
        exp_t r;
        logic [NT-1:0] pick;
        bit phase_free;
        r = '0;
        r.tag = tag;
        for (int pass = 0; pass < 2; pass++) begin
            phase_free = (pass == 0);
            pick = '0;
            for (int i = 0; i < NT; i++) begin
                bit ok;
                ok = a[m_src[i]] && (!m_grd[i] || c[i]);
                if (phase_free) ok = ok && !m_evt[i] && s;
                else            ok = ok && m_evt[i] && ((m_mask[i] & e) != 0);
                for (int j = 0; j < i; j++) if (m_yield[i][j] && pick[j]) ok = 0;
                pick[i] = ok;
            end
            if (phase_free && pick != 0) begin
                r.sel = pick; r.efree = 1; break;
            end
            if (!phase_free) begin
                r.sel = pick; r.econs = (pick != 0);
            end
        end
        r.anyf = (r.sel != 0);
        return r;
    endfunction

    task automatic drive(logic [NS-1:0] a, logic [NE-1:0] e, logic s,
                         logic [NT-1:0] c, logic [7:0] tag);
        @(negedge clk);
        active_states = a; event_onehot = e; spont_en = s; cond_ok = c;
        sb_q.push_back(model(a, e, s, c, tag));
    endtask

    // Hand-worked case: check the model itself against a value worked out by hand
    task automatic expect_hand(logic [NT-1:0] want, string req, logic [7:0] tag);
        exp_t m;
        m = sb_q[$];
        n_chk++;
        if (m.sel !== want) begin
            n_bad++;
            $display("FAIL %s case %0d: model %b expected %b", req, tag, m.sel, want);
        end
    endtask

    always @(posedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t x;
            x = sb_q.pop_front();
            n_chk++;
            if (fire_sel !== x.sel || eventless_fired !== x.efree ||
                event_consumed !== x.econs || any_fired !== x.anyf) begin
                n_bad++;
                $display("FAIL R1-R10 case %0d (R7 R8 R9 flags): got sel=%b ef=%b ec=%b any=%b expected sel=%b ef=%b ec=%b any=%b",
                         x.tag, fire_sel, eventless_fired, event_consumed, any_fired,
                         x.sel, x.efree, x.econs, x.anyf);
            end
        end
    end

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NT; i++) for (int j = 0; j < NT; j++) m_yield[i][j] = 0;
        m_yield[1][0] = 1; m_yield[2][0] = 1; m_yield[3][1] = 1;
        m_yield[4][2] = 1; m_yield[5][3] = 1; m_yield[5][4] = 1;
        m_grd[5] = 0;

        repeat (2) @(negedge clk);
        // reset-state check: all inputs idle, nothing fires
        n_chk++;
        if (fire_sel !== '0 || any_fired !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 reset: got %b expected 000000", fire_sel);
        end
        rst = 1'b0;

        drive(8'h02, 4'b0000, 1, 6'b000000, 1);  expect_hand(6'b000001, "R2", 1);
        drive(8'h02, 4'b0000, 0, 6'b000000, 2);  expect_hand(6'b000000, "R2", 2);
        drive(8'h06, 4'b0000, 1, 6'b000010, 3);  expect_hand(6'b000001, "R5", 3);
        drive(8'h04, 4'b0000, 1, 6'b000010, 4);  expect_hand(6'b000010, "R3", 4);
        drive(8'h04, 4'b0000, 1, 6'b000000, 5);  expect_hand(6'b000000, "R3", 5);
        drive(8'h02, 4'b0010, 0, 6'b000000, 6);  expect_hand(6'b000100, "R4", 6);
        drive(8'h02, 4'b0001, 0, 6'b000000, 7);  expect_hand(6'b000100, "R5", 7);
        drive(8'h02, 4'b1000, 0, 6'b000000, 8);  expect_hand(6'b010000, "R4", 8);
        drive(8'h12, 4'b0100, 1, 6'b000000, 9);  expect_hand(6'b000001, "R6", 9);
        drive(8'h10, 4'b0100, 1, 6'b000000, 10); expect_hand(6'b100000, "R8", 10);
        drive(8'h10, 4'b0000, 0, 6'b000000, 11); expect_hand(6'b000000, "R10", 11);
        drive(8'h18, 4'b0100, 0, 6'b001000, 12); expect_hand(6'b001000, "R5", 12);
        drive(8'h18, 4'b0100, 0, 6'b000000, 13); expect_hand(6'b100000, "R3", 13);
        drive(8'hE1, 4'b0010, 0, 6'b111111, 14); expect_hand(6'b000000, "R1", 14);
        drive(8'h02, 4'b0000, 1, 6'b111111, 15); expect_hand(6'b000001, "R7", 15);

        for (int k = 0; k < 400; k++) begin
            logic [NE-1:0] ev;
            int pick;
            pick = $urandom_range(0, NE);
            ev = (pick == NE) ? '0 : (NE'(1) << pick);
            drive(NS'($urandom), ev, 1'($urandom), NT'($urandom), 8'(100 + (k % 100)));
        end

        @(negedge clk);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule